// File: doc/BRIEF.md
# SDRAM Command Decoder and Sequencing Checker

This block watches the control pins of a four-bank SDRAM device from the controller side. On every rising clock edge it turns the sampled clock-enable, chip-select, row/column strobes, write enable, bank address, auto-precharge bit and data-mask pin into a decoded command. It keeps a small state record per bank: closed, open, or closing on its own after an auto-precharge access. Commands that break the ordering rules of the device are reported with a one-cycle violation pulse and a reason code. A violating command is treated as if it never happened, so one bad command does not corrupt later checking.

The block also re-times the data-mask pin into two strobes. The write strobe applies in the same cycle as the command outputs. The read strobe is the same mask delayed by two cycles, because that is when it forces read data to high impedance. The block is meant to sit beside a memory controller or a pin-level model as a protocol monitor. It has no path back into the controller.

All outputs are registered. Each output shows the pins sampled at the most recent rising edge, or the bank state after that edge.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: The command code is decoded only if `cke` was high at the previous edge. With `cs_n` high the code is 1 (deselect). With `cs_n` low, `{ras_n,cas_n,we_n}` decodes as follows: 111 gives 2 (no-op), 000 gives 3 (mode set), 001 gives 4 (auto refresh) when `cke` is high now and 5 (self-refresh entry) when it is low, 011 gives 6 (activate), 101 gives 7 (read), 100 gives 8 (write), 010 gives 9 (single-bank precharge) with `ap` low and 10 (precharge of every bank) with `ap` high, and 110 gives 11 (reserved).
- R2: If `cke` was low at the previous edge, the code is 0. There is then no violation and no change of bank state.
- R3: For codes 6 to 9, `cmd_bank` equals `ba` and `bank_sel` has the single bit `ba` set, where `ba` values 0 to 3 select banks A to D. For codes 3, 4, 5 and 10, `bank_sel` is 4'b1111. For all other codes both outputs are zero.
- R4: A mode set while any bank is open or locked is flagged with reason 1.
- R5: In the two cycles after a legal mode set, any code other than 0, 1 or 2 is flagged with reason 3. This check takes priority over every other reason.
- R6: An auto refresh or a self-refresh entry while any bank is open or locked is flagged with reason 2.
- R7: A read or write to a bank that is not open is flagged with reason 4. An activate to a bank that is open or locked is flagged with reason 5.
- R8: A legal read or write with `ap` high closes the bank and locks it for BL edges. A read or write to that bank during the lock is flagged with reason 6. The other banks stay accessible. After the lock the bank is idle.
- R9: A legal mode set loads the burst length from `mode_bl`: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8. Any other value keeps the current length. After reset the length is the parameter `BL_DEFAULT`.
- R10: A legal single-bank precharge closes only the bank it addresses. A legal precharge of every bank closes all banks whatever `ba` holds. Either kind also clears an auto-precharge lock.
- R11: A flagged command changes no bank state, no burst length and no settling window. `viol` is high exactly when `viol_code` is non-zero.
- R12: `wr_mask` equals `dqm` at the same edge as the command outputs (latency 0). `rd_hiz` equals `dqm` from two edges earlier (latency 2).
- R13: After a synchronous reset every output is zero and all banks are closed and unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| ap | input | 1 | Auto-precharge / all-banks address bit |
| mode_bl | input | 3 | Burst-length field of the mode set address |
| dqm | input | 1 | Data mask pin |
| cmd_code | output | 4 | Decoded command code |
| cmd_bank | output | BA_W | Target bank of a banked command |
| bank_sel | output | 2**BA_W | Banks touched by the command (one-hot or all ones) |
| viol | output | 1 | Violation pulse |
| viol_code | output | 3 | Violation reason |
| bank_active | output | 2**BA_W | Bank open flags |
| bank_locked | output | 2**BA_W | Auto-precharge lock flags |
| wr_mask | output | 1 | Write data mask strobe |
| rd_hiz | output | 1 | Read data high-impedance strobe |

## Verification
Directed sequences exercise each rule on its own. They cover a mode set with banks open and with all banks closed, commands placed inside and just after the settling window, double activation, access to a closed bank, and an auto-precharge lock touched on its first and last edge, with a second bank used during the lock. These sequences show that each reason code fires alone and with the right priority. A long random run then mixes every command with random bank addresses, clock-enable dropouts and mask values. A bench model computes every expected output each cycle. The random run brings out errors in priority, in lock counting and in bank-state updates that fixed sequences miss, and it checks the two mask latencies against each other on every cycle.

// File: rtl/smon_pkg.sv
`timescale 1ns/1ps
package smon_pkg;

    localparam int BLW = 4;

    typedef enum logic [3:0] {
        CMD_NONE     = 4'd0,
        CMD_DESEL    = 4'd1,
        CMD_NOP      = 4'd2,
        CMD_MODESET  = 4'd3,
        CMD_AUTOREF  = 4'd4,
        CMD_SELFREF  = 4'd5,
        CMD_ACTIVATE = 4'd6,
        CMD_READ     = 4'd7,
        CMD_WRITE    = 4'd8,
        CMD_PRE_ONE  = 4'd9,
        CMD_PRE_ALL  = 4'd10,
        CMD_RSVD     = 4'd11
    } cmd_e;

    typedef enum logic [2:0] {
        V_OK           = 3'd0,
        V_MODE_BUSY    = 3'd1,
        V_REF_BUSY     = 3'd2,
        V_SETTLE       = 3'd3,
        V_NOT_OPEN     = 3'd4,
        V_ALREADY_OPEN = 3'd5,
        V_AP_LOCK      = 3'd6
    } viol_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    function automatic cmd_e decode_cmd(input logic cke_prev, input logic cke_now,
                                        input logic ap, input pins_t p);
        if (!cke_prev) return CMD_NONE;
        if (p.cs_n)    return CMD_DESEL;
        case ({p.ras_n, p.cas_n, p.we_n})
            3'b111:  return CMD_NOP;
            3'b000:  return CMD_MODESET;
            3'b001:  return cke_now ? CMD_AUTOREF : CMD_SELFREF;
            3'b011:  return CMD_ACTIVATE;
            3'b101:  return CMD_READ;
            3'b100:  return CMD_WRITE;
            3'b010:  return ap ? CMD_PRE_ALL : CMD_PRE_ONE;
            default: return CMD_RSVD;
        endcase
    endfunction

    function automatic logic [BLW-1:0] bl_decode(input logic [2:0] code,
                                                 input logic [BLW-1:0] cur);
        case (code)
            3'd0:    return BLW'(1);
            3'd1:    return BLW'(2);
            3'd2:    return BLW'(4);
            3'd3:    return BLW'(8);
            default: return cur;
        endcase
    endfunction

    function automatic logic is_quiet(input cmd_e c);
        return (c == CMD_NONE) || (c == CMD_DESEL) || (c == CMD_NOP);
    endfunction

    function automatic logic is_rw(input cmd_e c);
        return (c == CMD_READ) || (c == CMD_WRITE);
    endfunction

endpackage

// File: rtl/smon_decode.sv
`timescale 1ns/1ps
module smon_decode
    import smon_pkg::*;
#(
    parameter int BA_W = 2,
    localparam int NB  = 1 << BA_W
) (
    input  logic            cke_prev,
    input  logic            cke_now,
    input  pins_t           pins,
    input  logic [BA_W-1:0] ba,
    input  logic            ap,
    output cmd_e            cmd_o,
    output logic            banked_o,
    output logic [NB-1:0]   sel_o
);
    logic global_cmd;

    always_comb begin
        cmd_o      = decode_cmd(cke_prev, cke_now, ap, pins);
        banked_o   = (cmd_o == CMD_ACTIVATE) || is_rw(cmd_o) || (cmd_o == CMD_PRE_ONE);
        global_cmd = (cmd_o == CMD_MODESET) || (cmd_o == CMD_AUTOREF) ||
                     (cmd_o == CMD_SELFREF) || (cmd_o == CMD_PRE_ALL);
        if (global_cmd)    sel_o = '1;
        else if (banked_o) sel_o = NB'(1) << ba;
        else               sel_o = '0;
    end
endmodule

// File: rtl/smon_bank.sv
`timescale 1ns/1ps
module smon_bank #(
    parameter int BLW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           open_i,
    input  logic           close_i,
    input  logic           ap_i,
    input  logic [BLW-1:0] bl_i,
    output logic           active_o,
    output logic           locked_o
);
    logic [BLW-1:0] lock_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_o <= 1'b0;
            lock_cnt <= '0;
        end else if (close_i) begin
            active_o <= 1'b0;
            lock_cnt <= '0;
        end else if (ap_i) begin
            active_o <= 1'b0;
            lock_cnt <= bl_i;
        end else begin
            if (open_i) active_o <= 1'b1;
            if (lock_cnt != '0) lock_cnt <= lock_cnt - 1'b1;
        end
    end

    assign locked_o = (lock_cnt != '0);
endmodule

// File: rtl/smon_dqm_pipe.sv
`timescale 1ns/1ps
module smon_dqm_pipe #(
    parameter int WR_LAT = 0,
    parameter int RD_LAT = 2,
    localparam int DEPTH = ((WR_LAT > RD_LAT) ? WR_LAT : RD_LAT) + 1
) (
    input  logic clk,
    input  logic rst,
    input  logic dqm,
    output logic wr_mask,
    output logic rd_hiz
);
    logic [DEPTH-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
        end else begin
            stage[0] <= dqm;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
    end

    assign wr_mask = stage[WR_LAT];
    assign rd_hiz  = stage[RD_LAT];
endmodule

// File: rtl/sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sdram_cmd_monitor
    import smon_pkg::*;
#(
    parameter int BA_W        = 2,
    parameter int BL_DEFAULT  = 4,
    parameter int WR_MASK_LAT = 0,
    parameter int RD_MASK_LAT = 2,
    parameter int MRS_SETTLE  = 2,
    localparam int NB         = 1 << BA_W,
    localparam int SW         = $clog2(MRS_SETTLE + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cke,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            ap,
    input  logic [2:0]      mode_bl,
    input  logic            dqm,
    output logic [3:0]      cmd_code,
    output logic [BA_W-1:0] cmd_bank,
    output logic [NB-1:0]   bank_sel,
    output logic            viol,
    output logic [2:0]      viol_code,
    output logic [NB-1:0]   bank_active,
    output logic [NB-1:0]   bank_locked,
    output logic            wr_mask,
    output logic            rd_hiz
);
    logic           cke_q;
    logic [SW-1:0]  settle_q;
    logic [BLW-1:0] bl_q;
    cmd_e           cmd_d;
    logic           banked_d;
    logic [NB-1:0]  sel_d;
    viol_e          viol_d;
    logic           legal;
    logic           all_idle;
    logic [NB-1:0]  open_v, close_v, ap_v;
    pins_t          pins;

    assign pins = '{cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n};

    smon_decode #(.BA_W(BA_W)) u_decode (
        .cke_prev (cke_q),
        .cke_now  (cke),
        .pins     (pins),
        .ba       (ba),
        .ap       (ap),
        .cmd_o    (cmd_d),
        .banked_o (banked_d),
        .sel_o    (sel_d)
    );

    assign all_idle = ~|(bank_active | bank_locked);

    always_comb begin
        viol_d = V_OK;
        if (settle_q != '0 && !is_quiet(cmd_d)) begin
            viol_d = V_SETTLE;
        end else begin
            case (cmd_d)
                CMD_MODESET:  if (!all_idle) viol_d = V_MODE_BUSY;
                CMD_AUTOREF,
                CMD_SELFREF:  if (!all_idle) viol_d = V_REF_BUSY;
                CMD_ACTIVATE: if (bank_active[ba] || bank_locked[ba]) viol_d = V_ALREADY_OPEN;
                CMD_READ,
                CMD_WRITE: begin
                    if (bank_locked[ba])       viol_d = V_AP_LOCK;
                    else if (!bank_active[ba]) viol_d = V_NOT_OPEN;
                end
                default: viol_d = V_OK;
            endcase
        end
    end

    assign legal   = (viol_d == V_OK);
    assign open_v  = (legal && cmd_d == CMD_ACTIVATE) ? sel_d : '0;
    assign ap_v    = (legal && is_rw(cmd_d) && ap) ? sel_d : '0;
    assign close_v = (legal && (cmd_d == CMD_PRE_ONE || cmd_d == CMD_PRE_ALL)) ? sel_d : '0;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        smon_bank #(.BLW(BLW)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .open_i   (open_v[g]),
            .close_i  (close_v[g]),
            .ap_i     (ap_v[g]),
            .bl_i     (bl_q),
            .active_o (bank_active[g]),
            .locked_o (bank_locked[g])
        );
    end

    smon_dqm_pipe #(.WR_LAT(WR_MASK_LAT), .RD_LAT(RD_MASK_LAT)) u_dqm (
        .clk     (clk),
        .rst     (rst),
        .dqm     (dqm),
        .wr_mask (wr_mask),
        .rd_hiz  (rd_hiz)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q     <= 1'b0;
            settle_q  <= '0;
            bl_q      <= BLW'(BL_DEFAULT);
            cmd_code  <= CMD_NONE;
            cmd_bank  <= '0;
            bank_sel  <= '0;
            viol      <= 1'b0;
            viol_code <= V_OK;
        end else begin
            cke_q <= cke;
            if (legal && cmd_d == CMD_MODESET) begin
                settle_q <= SW'(MRS_SETTLE);
                bl_q     <= bl_decode(mode_bl, bl_q);
            end else if (settle_q != '0) begin
                settle_q <= settle_q - 1'b1;
            end
            cmd_code  <= cmd_d;
            cmd_bank  <= banked_d ? ba : '0;
            bank_sel  <= sel_d;
            viol      <= !legal;
            viol_code <= viol_d;
        end
    end
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_chk
    import smon_pkg::*;
#(
    parameter int BA_W = 2,
    localparam int NB  = 1 << BA_W
) (
    input logic            clk,
    input logic            rst,
    input logic [3:0]      cmd_code,
    input logic [BA_W-1:0] cmd_bank,
    input logic [NB-1:0]   bank_sel,
    input logic            viol,
    input logic [2:0]      viol_code,
    input logic [NB-1:0]   bank_active,
    input logic [NB-1:0]   bank_locked,
    input logic            wr_mask,
    input logic            rd_hiz
);
    logic [1:0] cyc;
    always_ff @(posedge clk) begin
        if (rst)            cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    p_sel_all_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == CMD_PRE_ALL) |-> (bank_sel == '1));

    p_sel_one_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == CMD_READ || cmd_code == CMD_WRITE || cmd_code == CMD_ACTIVATE)
        |-> ($countones(bank_sel) == 1));

    p_mrs_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (cyc != 2'd0 && cmd_code == CMD_MODESET && !viol)
        |-> ($past(bank_active) == '0 && $past(bank_locked) == '0));

    p_settle_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == CMD_MODESET && !viol)
        |=> (cmd_code == CMD_NONE || cmd_code == CMD_DESEL || cmd_code == CMD_NOP
             || viol_code == V_SETTLE));

    p_rw_open_r7: assert property (@(posedge clk) disable iff (rst)
        (cyc != 2'd0 && (cmd_code == CMD_READ || cmd_code == CMD_WRITE) && !viol)
        |-> (($past(bank_active) & (NB'(1) << cmd_bank)) != '0));

    p_freeze_r11: assert property (@(posedge clk) disable iff (rst)
        (cyc != 2'd0 && viol) |-> $stable(bank_active));

    p_mask_lat_r12: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd3) |-> (rd_hiz == $past(wr_mask, 2)));
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.BA_W(BA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_code    (cmd_code),
    .cmd_bank    (cmd_bank),
    .bank_sel    (bank_sel),
    .viol        (viol),
    .viol_code   (viol_code),
    .bank_active (bank_active),
    .bank_locked (bank_locked),
    .wr_mask     (wr_mask),
    .rd_hiz      (rd_hiz)
);

// File: tb/test_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module test_sdram_cmd_monitor;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst, cke, cs_n, ras_n, cas_n, we_n, ap, dqm;
    logic [1:0] ba;
    logic [2:0] mode_bl;
    logic [3:0] cmd_code, bank_sel, bank_active, bank_locked;
    logic [1:0] cmd_bank;
    logic       viol, wr_mask, rd_hiz;
    logic [2:0] viol_code;

    sdram_cmd_monitor i_sdram_cmd_monitor (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .ap(ap), .mode_bl(mode_bl), .dqm(dqm),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .bank_sel(bank_sel), .viol(viol),
        .viol_code(viol_code), .bank_active(bank_active), .bank_locked(bank_locked),
        .wr_mask(wr_mask), .rd_hiz(rd_hiz));

    int checks = 0, failures = 0;
    bit done = 0;

    // reference model state
    bit m_cke_q;
    bit m_act [4];
    int m_cnt [4];
    int m_bl, m_settle;
    bit m_d1, m_d2;
    int e_cmd, e_bank, e_sel, e_code, e_wr, e_rd;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int pack_act();
        int v = 0;
        for (int b = 0; b < 4; b++) if (m_act[b]) v |= (1 << b);
        return v;
    endfunction

    function automatic int pack_lock();
        int v = 0;
        for (int b = 0; b < 4; b++) if (m_cnt[b] > 0) v |= (1 << b);
        return v;
    endfunction

    function automatic void model_reset();
        m_cke_q = 0; m_bl = 4; m_settle = 0; m_d1 = 0; m_d2 = 0;
        for (int b = 0; b < 4; b++) begin m_act[b] = 0; m_cnt[b] = 0; end
    endfunction

    function automatic void model_step(bit k, bit cs, bit r, bit c, bit w, int b,
                                       bit a, int bl, bit d);
        bit banked, glob, idle;
        int cm, code;
        if (!m_cke_q) cm = 0;
        else if (cs) cm = 1;
        else case ({r, c, w})
            3'b111: cm = 2;
            3'b000: cm = 3;
            3'b001: cm = k ? 4 : 5;
            3'b011: cm = 6;
            3'b101: cm = 7;
            3'b100: cm = 8;
            3'b010: cm = a ? 10 : 9;
            default: cm = 11;
        endcase
        banked = (cm >= 6 && cm <= 9);
        glob   = (cm == 3 || cm == 4 || cm == 5 || cm == 10);
        e_cmd  = cm;
        e_bank = banked ? b : 0;
        e_sel  = glob ? 15 : (banked ? (1 << b) : 0);
        idle   = (pack_act() == 0) && (pack_lock() == 0);
        code   = 0;
        if (m_settle > 0 && cm > 2) code = 3;
        else case (cm)
            3: code = idle ? 0 : 1;
            4, 5: code = idle ? 0 : 2;
            6: code = (m_act[b] || m_cnt[b] > 0) ? 5 : 0;
            7, 8: code = (m_cnt[b] > 0) ? 6 : (!m_act[b] ? 4 : 0);
            default: code = 0;
        endcase
        e_code = code;
        for (int i = 0; i < 4; i++) if (m_cnt[i] > 0) m_cnt[i]--;
        if (code == 0) begin
            case (cm)
                6: m_act[b] = 1;
                7, 8: if (a) begin m_act[b] = 0; m_cnt[b] = m_bl; end
                9: begin m_act[b] = 0; m_cnt[b] = 0; end
                10: for (int i = 0; i < 4; i++) begin m_act[i] = 0; m_cnt[i] = 0; end
                default: ;
            endcase
        end
        if (cm == 3 && code == 0) begin
            m_settle = 2;
            if (bl < 4) m_bl = 1 << bl;
        end else if (m_settle > 0) m_settle--;
        e_wr = d; e_rd = m_d2; m_d2 = m_d1; m_d1 = d;
        m_cke_q = k;
    endfunction

    task automatic step(bit k, bit cs, bit r, bit c, bit w, int b, bit a, int bl, string req);
        bit d = 1'($urandom % 2);
        cke = k; cs_n = cs; ras_n = r; cas_n = c; we_n = w;
        ba = 2'(b); ap = a; mode_bl = 3'(bl); dqm = d;
        @(posedge clk);
        model_step(k, cs, r, c, w, b, a, bl, d);
        @(negedge clk);
        chk(req, "cmd_code", cmd_code, e_cmd);
        chk(req, "cmd_bank", cmd_bank, e_bank);
        chk(req, "bank_sel", bank_sel, e_sel);
        chk(req, "viol_code", viol_code, e_code);
        chk(req, "viol", viol, (e_code != 0) ? 1 : 0);
        chk(req, "bank_active", bank_active, pack_act());
        chk(req, "bank_locked", bank_locked, pack_lock());
        chk(req, "wr_mask R12", wr_mask, e_wr);
        chk(req, "rd_hiz R12", rd_hiz, e_rd);
    endtask

    task automatic nop(string req);           step(1, 0, 1, 1, 1, 0, 0, 0, req); endtask
    task automatic mrs(int bl, string req);   step(1, 0, 0, 0, 0, 0, 0, bl, req); endtask
    task automatic act(int b, string req);    step(1, 0, 0, 1, 1, b, 0, 0, req); endtask
    task automatic rd(int b, bit a, string req); step(1, 0, 1, 0, 1, b, a, 0, req); endtask
    task automatic wr(int b, bit a, string req); step(1, 0, 1, 0, 0, b, a, 0, req); endtask
    task automatic pre(int b, bit a, string req); step(1, 0, 0, 1, 0, b, a, 0, req); endtask
    task automatic refr(bit k, string req);   step(k, 0, 0, 0, 1, 0, 0, 0, req); endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240601));
        rst = 1; cke = 1; cs_n = 0; ras_n = 1; cas_n = 1; we_n = 1;
        ba = 0; ap = 0; mode_bl = 0; dqm = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13: reset state
        chk("R13", "cmd_code", cmd_code, 0);
        chk("R13", "viol", viol, 0);
        chk("R13", "bank_active", bank_active, 0);
        chk("R13", "bank_locked", bank_locked, 0);
        chk("R13", "rd_hiz", rd_hiz, 0);
        rst = 0;

        nop("R2");              // cke_q still low from reset: code 0
        nop("R1");
        mrs(1, "R9");           // legal, BL = 2
        act(1, "R5");           // inside window: reason 3, no effect (R11)
        nop("R5");
        act(1, "R3");           // window over: bank B opens
        act(1, "R7");           // reason 5
        rd(2, 0, "R7");         // reason 4
        mrs(0, "R4");           // reason 1, BL kept (R11)
        refr(1, "R6");          // reason 2
        act(2, "R3");
        rd(1, 1, "R8");         // auto-precharge, locked 2 edges
        wr(1, 0, "R8");         // reason 6
        rd(2, 0, "R8");         // other bank legal, lock ends
        wr(1, 0, "R8");         // bank B now idle: reason 4
        pre(2, 0, "R10");       // closes only bank C
        act(0, "R10");
        act(3, "R10");
        pre(1, 1, "R10");       // all-banks precharge ignores ba
        mrs(7, "R9");           // unsupported code keeps BL = 2
        nop("R5"); nop("R5");
        act(0, "R9");
        wr(0, 1, "R9");         // lock length follows BL = 2
        rd(0, 0, "R9");
        rd(0, 0, "R9");
        nop("R1");
        refr(0, "R6");          // self-refresh entry, all idle
        refr(0, "R2");          // clock disabled: code 0
        nop("R2");              // cke high again, previous still low
        nop("R1");
        step(1, 1, 0, 0, 0, 0, 0, 0, "R1");   // deselect
        step(1, 0, 1, 1, 0, 0, 0, 0, "R1");   // reserved
        mrs(3, "R9");           // BL = 8
        nop("R5"); nop("R5");
        act(3, "R8"); rd(3, 1, "R8");
        for (int i = 0; i < 8; i++) rd(3, 0, "R8");
        wr(3, 0, "R8");

        for (int n = 0; n < 3000; n++) begin
            bit k = (($urandom % 100) < 5) ? 1'b0 : 1'b1;
            int b = int'($urandom % 4);
            bit a = 1'($urandom % 2);
            int bl = int'($urandom % 8);
            case ($urandom % 12)
                0, 1:  step(k, 0, 1, 1, 1, b, a, bl, "R1");
                2, 3:  step(k, 0, 0, 1, 1, b, a, bl, "R7");
                4:     step(k, 0, 1, 0, 1, b, a, bl, "R8");
                5:     step(k, 0, 1, 0, 0, b, a, bl, "R8");
                6, 7:  step(k, 0, 0, 1, 0, b, a, bl, "R10");
                8:     step(k, 0, 0, 0, 0, b, a, bl, "R4");
                9:     step(k, 0, 0, 0, 1, b, a, bl, "R6");
                10:    step(k, 1, 0, 0, 0, b, a, bl, "R11");
                default: step(k, 0, 1, 1, 0, b, a, bl, "R1");
            endcase
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule